// File: doc/BRIEF.md
# Three-Wire Serial Configuration Latch Loader

This block takes configuration words from a slow three-wire serial port (serial clock, serial data, load strobe) and places each word into one of four parallel configuration latches. Every pin of the port is treated as an ordinary asynchronous input. A much faster system clock samples each pin, and the block finds the edges it needs in that clock domain.

Each word is 24 bits long and is sent with its most significant bit first. A rising edge of the load strobe copies the shift register into a latch. The two lowest bits of the word are a destination code that chooses which latch is written. After each write the block gives a one-cycle strobe together with the index of the latch it wrote.

A separate chip-enable pin drives a power-down flag and a charge-pump enable output. The surrounding synthesizer logic reads the four latch outputs directly and decodes their fields itself.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is asserted and right after it, all four latches read zero, `cfg_wr_stb` is low and `power_down` is high because `chip_en` is held low.
- R2: Each synchronised rising edge of `ser_clk` shifts `ser_data` into a 24-bit register, with the most significant bit first. Bit 23 of a word is sent first and bit 0 is sent last.
- R3: Word bits [1:0] are the destination code. Code k (0 to 3) selects latch k, and latch k occupies bits [24*k+23 : 24*k] of `cfg_latches`.
- R4: A rising edge of `ser_load` copies all 24 bits of the shift register, control bits included, into the selected latch. The other three latches keep their values.
- R5: The write is visible on `cfg_latches` three system clock edges after `ser_load` rises. In that same cycle `cfg_wr_stb` is high for exactly one cycle and `cfg_wr_idx` carries the destination code.
- R6: `ser_clk` rising edges that arrive while `ser_load` is high do not change the shift register. A later load therefore writes the word that was held before those edges.
- R7: Two system clock edges after a change of `chip_en`, `power_down` equals the inverse of `chip_en` and `pump_en` equals `chip_en`.
- R8: Holding `ser_load` high for many cycles produces only one write and one strobe.
- R9: When more than 24 bits are shifted before a load, only the last 24 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, sent most significant bit first |
| ser_load | input | 1 | Load strobe; a rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low means power down |
| cfg_latches | output | 96 | The four 24-bit latches, latch k at [24*k+23 : 24*k] |
| cfg_wr_stb | output | 1 | One-cycle pulse after each latch write |
| cfg_wr_idx | output | 2 | Index of the latch written, valid with `cfg_wr_stb` |
| power_down | output | 1 | High while chip enable is low |
| pump_en | output | 1 | Charge-pump enable, low in power down |

## Verification
A latch write and its strobe are due three system clock edges after `ser_load` rises: two synchroniser stages, then the latch register. The bench raises the load strobe on a falling edge, waits exactly three rising edges and samples on the next falling edge. It checks the strobe once more one cycle later to confirm that it has dropped. The chip-enable outputs are due after two edges and are sampled the same way. Serial bits are held for several system cycles on each side of every serial clock edge, so each bit is settled in the synchronised domain before it is captured.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WORD_W      = 24;
  localparam int SEL_W       = 2;
  localparam int NUM_LATCH   = 1 << SEL_W;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/cfg_sync.sv
// Multi-bit chain of flip-flops that brings asynchronous pins into the clk domain.
module cfg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
// Shift register fed on rising edges of the synchronised serial clock.
module cfg_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              sload_s,
  output logic [WORD_W-1:0] word
);
  logic              sclk_d;
  logic              sclk_rise;
  logic              shift_en;
  logic [WORD_W-1:0] shreg_q, shreg_nxt;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign shift_en  = sclk_rise & ~sload_s;

  always_comb begin
    shreg_nxt = shreg_q;
    if (shift_en) shreg_nxt = {shreg_q[WORD_W-2:0], sdata_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      shreg_q <= '0;
    end else begin
      sclk_d  <= sclk_s;
      shreg_q <= shreg_nxt;
    end
  end

  assign word = shreg_q;

  // R6
  shreg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sload_s |=> $stable(shreg_q));
endmodule

// File: rtl/cfg_latch_bank.sv
// Four configuration latches, written on a load-strobe rising edge.
module cfg_latch_bank #(
  parameter int WORD_W    = 24,
  parameter int SEL_W     = 2,
  parameter int NUM_LATCH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sload_s,
  input  logic [WORD_W-1:0]           word,
  output logic [NUM_LATCH*WORD_W-1:0] latches,
  output logic                        wr_stb,
  output logic [SEL_W-1:0]            wr_idx
);
  logic              load_d;
  logic              load_rise;
  logic              stb_q, stb_nxt;
  logic [SEL_W-1:0]  idx_q, idx_nxt;
  logic [WORD_W-1:0] latch_q   [NUM_LATCH];
  logic [WORD_W-1:0] latch_nxt [NUM_LATCH];

  assign load_rise = sload_s & ~load_d;

  always_comb begin
    stb_nxt = load_rise;
    idx_nxt = load_rise ? word[SEL_W-1:0] : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_d <= 1'b0;
      stb_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      load_d <= sload_s;
      stb_q  <= stb_nxt;
      idx_q  <= idx_nxt;
    end
  end

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
    always_comb begin
      latch_nxt[g] = latch_q[g];
      if (load_rise && (word[SEL_W-1:0] == SEL_W'(g))) latch_nxt[g] = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q[g] <= '0;
      else        latch_q[g] <= latch_nxt[g];
    end

    assign latches[g*WORD_W +: WORD_W] = latch_q[g];

    // R4
    only_selected_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(latch_q[g]) |-> (stb_q && (idx_q == SEL_W'(g))));
  end

  assign wr_stb = stb_q;
  assign wr_idx = idx_q;

  // R5
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R3
  idx_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (latch_q[idx_q][SEL_W-1:0] == idx_q));
endmodule

// File: rtl/serial_cfg_loader.sv
// Top level: pin synchronisers, serial shifter, latch bank, power-down outputs.
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_BITS  = WORD_W,
  parameter int CODE_BITS  = SEL_W,
  parameter int SYNC_DEPTH = SYNC_STAGES,
  localparam int LATCHES   = 1 << CODE_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_clk,
  input  logic                          ser_data,
  input  logic                          ser_load,
  input  logic                          chip_en,
  output logic [LATCHES*WORD_BITS-1:0]  cfg_latches,
  output logic                          cfg_wr_stb,
  output logic [CODE_BITS-1:0]          cfg_wr_idx,
  output logic                          power_down,
  output logic                          pump_en
);
  logic [3:0]           pins_s;
  logic [WORD_BITS-1:0] word;

  cfg_sync #(.WIDTH(4), .STAGES(SYNC_DEPTH)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({chip_en, ser_load, ser_data, ser_clk}),
    .q     (pins_s)
  );

  cfg_shifter #(.WORD_W(WORD_BITS)) i_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s[0]),
    .sdata_s (pins_s[1]),
    .sload_s (pins_s[2]),
    .word    (word)
  );

  cfg_latch_bank #(
    .WORD_W    (WORD_BITS),
    .SEL_W     (CODE_BITS),
    .NUM_LATCH (LATCHES)
  ) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sload_s (pins_s[2]),
    .word    (word),
    .latches (cfg_latches),
    .wr_stb  (cfg_wr_stb),
    .wr_idx  (cfg_wr_idx)
  );

  assign power_down = ~pins_s[3];
  assign pump_en    = pins_s[3];

  // R7
  pump_off_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> !pump_en);
endmodule

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
  localparam int W = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_data, ser_load, chip_en;
  logic [95:0] cfg_latches;
  logic        cfg_wr_stb;
  logic [1:0]  cfg_wr_idx;
  logic        power_down, pump_en;

  int errors = 0;
  int checks = 0;
  int stb_count = 0;
  bit done = 0;

  logic [W-1:0] sh_model;
  logic [W-1:0] exp_l [4];

  always #2 clk = ~clk;

  serial_cfg_loader i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .chip_en(chip_en), .cfg_latches(cfg_latches),
    .cfg_wr_stb(cfg_wr_stb), .cfg_wr_idx(cfg_wr_idx),
    .power_down(power_down), .pump_en(pump_en)
  );

  always @(negedge clk) if (cfg_wr_stb) stb_count++;

  function automatic logic [95:0] exp_bus();
    return {exp_l[3], exp_l[2], exp_l[1], exp_l[0]};
  endfunction

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [63:0] bits, input int n, input bit track);
    for (int b = n - 1; b >= 0; b--) begin
      @(negedge clk); ser_data = bits[b];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (8) @(negedge clk); ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      if (track) sh_model = {sh_model[W-2:0], bits[b]};
    end
  endtask

  task automatic do_load(input int hold, input string req);
    logic [1:0] code;
    code = sh_model[1:0];
    exp_l[code] = sh_model;
    @(negedge clk); ser_load = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({req, " strobe"}, {95'd0, cfg_wr_stb}, 96'd1);
    check({req, " index"}, {94'd0, cfg_wr_idx}, {94'd0, code});
    check({req, " latches"}, cfg_latches, exp_bus());
    @(negedge clk);
    check({req, " strobe drop R5"}, {95'd0, cfg_wr_stb}, 96'd0);
    repeat (hold) @(negedge clk);
    ser_load = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ser_clk = 0; ser_data = 0; ser_load = 0; chip_en = 0;
    sh_model = '0;
    for (int i = 0; i < 4; i++) exp_l[i] = '0;
    repeat (5) @(negedge clk);
    // R1 during reset
    check("R1 latches in reset", cfg_latches, 96'd0);
    check("R1 strobe in reset", {95'd0, cfg_wr_stb}, 96'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 latches after reset", cfg_latches, 96'd0);
    check("R1 power_down", {95'd0, power_down}, 96'd1);

    // R7 chip enable up
    chip_en = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R7 power_down low", {95'd0, power_down}, 96'd0);
    check("R7 pump_en high", {95'd0, pump_en}, 96'd1);

    // R2 R3 R4 directed: one word per latch code
    send_bits(64'hA5C3F0, 24, 1); do_load(2, "R2 R3 code0");
    send_bits(64'h123451, 24, 1); do_load(2, "R3 code1");
    send_bits(64'hFEDCBA, 24, 1); do_load(2, "R3 code2");
    send_bits(64'h00FF0F, 24, 1); do_load(2, "R4 code3");

    // R9 overlong shift keeps last 24 bits
    send_bits(64'h3F_ABCDE6, 30, 1); do_load(2, "R9 overlong");
    check("R9 latch2 value", {72'd0, exp_l[2]}, {72'd0, 24'hABCDE6});

    // R6 serial clocks during load are ignored
    send_bits(64'h5A5A59, 24, 1);
    do_load(0, "R6 first load");
    @(negedge clk); ser_load = 1'b1;
    repeat (4) @(negedge clk);
    send_bits(64'hFFFFFF, 24, 0);
    @(negedge clk); ser_load = 1'b0;
    repeat (4) @(negedge clk);
    do_load(2, "R6 reload unchanged");

    // R8 long hold gives one strobe
    send_bits(64'h777773, 24, 1);
    stb_count = 0;
    do_load(40, "R8 long hold");
    check("R8 strobe count", 96'(stb_count), 96'd1);

    // R2 R4 random words
    for (int n = 0; n < 20; n++) begin
      w = W'($urandom);
      send_bits({40'd0, w}, 24, 1);
      do_load($urandom_range(0, 5), "R2 R4 random");
    end

    // R7 chip enable down
    chip_en = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R7 power_down high", {95'd0, power_down}, 96'd1);
    check("R7 pump_en low", {95'd0, pump_en}, 96'd0);
    check("R4 latches kept in power down", cfg_latches, exp_bus());

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule